// File: doc/BRIEF.md
# Three-Channel Compare Timer

A 32-bit up-counting timer with a word-addressed register bank. Software programs the control word, a 12-bit prescaler, three compare values and an interrupt-enable mask. The counter advances on divided ticks of a selected source. Three compare channels and a rollover detector each set their own sticky status flag. A single level interrupt reports any enabled flag while the timer runs.

The register port is a plain single-cycle interface. A write takes effect at the clock edge where `reg_wr` is high. A read is combinational from `reg_addr`. The port never stalls, so there is no back-pressure. The tick sources come from outside as one-cycle enable pulses, because generating them is not part of this block. Capture inputs are not implemented. The two capture registers always read as zero.

Top module: `cmp_timer3`

## Requirements
- R1: The register index is `reg_addr >> 2`. The map is:
  - index 0: control
  - index 1: prescaler
  - index 2: status
  - index 3: interrupt enable
  - indices 4, 5, 6: compare 1, 2, 3
  - indices 7, 8: capture 1, 2, read-only, always zero
  - index 9: counter, read-only

  Any other index reads zero, and writes to it are ignored.
- R2: Control fields are: enable at bit 0, enable-mode at bit 1, clock-source select at bits [8:6], software reset at bit 15. On a control write, the bits in mask 0x7C14 are stored as zero.
- R3: The prescaler keeps only the low 12 bits of the written value. The counter advances once per (prescaler + 1) selected source ticks. Writing the prescaler restarts the division.
- R4: Source codes:
  - 000 and 111: no clock; the counter stays still.
  - 001 and 010: the peripheral tick `periph_tick`.
  - 011 to 110: the reference tick `ref_tick`.
- R5: A control write that takes enable from 0 to 1 with enable-mode set restarts the counter at zero. With enable-mode clear, the counter resumes from its held value. While the timer is disabled the counter holds.
- R6: Status bits 0, 1 and 2 are set in the clock edge where the counter steps onto the value of compare 1, 2 or 3 respectively.
- R7: Status bit 5 is set when the counter steps from its all-ones maximum to zero.
- R8: Status bits [5:0] are write-one-to-clear. Writing 0 to a bit leaves it unchanged. If an event sets a flag in the same edge that a write clears it, the set wins.
- R9: The interrupt-enable register holds the low 6 bits of the written value, in the same bit positions as the status register. `irq` is high exactly when (status AND enable) is nonzero and the control enable bit is set.
- R10: A control write with bit 15 set returns every register to its reset state, with the counter at zero. Control then reads as zero, because the reset bit clears itself.
- R11: After reset, these registers read zero: control, prescaler, status, interrupt enable, counter and both captures. Every compare register reads all ones. `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_tick | input | 1 | Peripheral clock tick enable (source codes 001/010) |
| ref_tick | input | 1 | Reference clock tick enable (source codes 011-110) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (12) | Byte address; index is bits [ADDR_W-1:2] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
Counting is tried against a table that varies three things at once: prescaler value, source code and the level of the reference tick. This separates the codes that select the peripheral tick, the reference tick and no clock. It also shows whether the divider yields floor(cycles/(prescaler+1)).

Compare matching is probed one cycle before and exactly at the match. This catches a flag that rises early or late. Rollover is probed at the all-ones count, where all three reset-valued compares fire first and the wrap flag follows one edge later.

Directed patterns cover:
- clearing one flag while another stays set;
- a clear landing in the same edge as a match;
- disable, resume and restart of the counter;
- control masking;
- software reset in the middle of a run.

// File: rtl/cmp_timer3_pkg.sv
package cmp_timer3_pkg;
  localparam int DATA_W = 32;
  localparam int STAT_W = 6;
  localparam int N_CMP  = 3;

  // control field positions (the write mask depends on them)
  localparam int CR_EN    = 0;
  localparam int CR_EMODE = 1;
  localparam int CR_SRC   = 6;
  localparam int CR_SWR   = 15;
  localparam logic [DATA_W-1:0] CR_ZERO_MASK = 32'h0000_7C14;

  // status / interrupt-enable bit positions
  localparam int ST_ROLL = 5;

  // register indices
  localparam int IX_CTRL = 0;
  localparam int IX_PRE  = 1;
  localparam int IX_STAT = 2;
  localparam int IX_IEN  = 3;
  localparam int IX_CMP0 = 4;
  localparam int IX_CAP0 = 7;
  localparam int IX_CAP1 = 8;
  localparam int IX_CNT  = 9;
endpackage

// File: rtl/cmp_timer3_tickgen.sv
module cmp_timer3_tickgen #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [2:0]       src_sel,
  input  logic             periph_tick,
  input  logic             ref_tick,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic             src_act;

  always_comb begin
    case (src_sel)
      3'd1, 3'd2:             src_act = periph_tick;
      3'd3, 3'd4, 3'd5, 3'd6: src_act = ref_tick;
      default:                src_act = 1'b0;
    endcase
  end

  assign tick = run && src_act && (pre_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pre_q <= '0;
    end else if (run && src_act) begin
      pre_q <= (pre_q == div) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmp_timer3_match.sv
module cmp_timer3_match #(
  parameter int CNT_W = 32,
  parameter int N_CH  = 3
) (
  input  logic                      step,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp_val,
  output logic [N_CH-1:0]           hit,
  output logic                      wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = cnt + 1'b1;
  assign wrap     = step && (cnt == CNT_MAX);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign hit[i] = step && (cnt_next == cmp_val[i]);
  end
endmodule

// File: rtl/cmp_timer3.sv
module cmp_timer3
  import cmp_timer3_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_tick,
  input  logic              ref_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [DATA_W-1:0]             cr_q;
  logic [PRE_W-1:0]              pr_q;
  logic [STAT_W-1:0]             sr_q;
  logic [STAT_W-1:0]             ir_q;
  logic [N_CMP-1:0][CNT_W-1:0]   ocr_q;
  logic [CNT_W-1:0]              cnt_q;

  logic [IDX_W-1:0] idx;
  logic wr_ctrl, swr, restart, wr_pre, wr_stat, wr_ien;
  logic tick, wrap;
  logic [N_CMP-1:0]  hit;
  logic [STAT_W-1:0] st_set, st_clr;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign wr_ctrl = reg_wr && (idx == IDX_W'(IX_CTRL));
  assign swr     = wr_ctrl && reg_wdata[CR_SWR];
  assign restart = wr_ctrl && !swr && reg_wdata[CR_EN] && !cr_q[CR_EN]
                   && reg_wdata[CR_EMODE];
  assign wr_pre  = reg_wr && (idx == IDX_W'(IX_PRE));
  assign wr_stat = reg_wr && (idx == IDX_W'(IX_STAT));
  assign wr_ien  = reg_wr && (idx == IDX_W'(IX_IEN));

  cmp_timer3_tickgen #(.PRE_W(PRE_W)) tick_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (swr || restart || wr_pre),
    .run        (cr_q[CR_EN]),
    .src_sel    (cr_q[CR_SRC +: 3]),
    .periph_tick(periph_tick),
    .ref_tick   (ref_tick),
    .div        (pr_q),
    .tick       (tick)
  );

  cmp_timer3_match #(.CNT_W(CNT_W), .N_CH(N_CMP)) match_i (
    .step   (tick),
    .cnt    (cnt_q),
    .cmp_val(ocr_q),
    .hit    (hit),
    .wrap   (wrap)
  );

  always_comb begin
    st_set = '0;
    st_set[N_CMP-1:0] = hit;
    st_set[ST_ROLL]   = wrap;
    st_clr = wr_stat ? reg_wdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || swr) begin
      cr_q  <= '0;
      pr_q  <= '0;
      sr_q  <= '0;
      ir_q  <= '0;
      ocr_q <= '1;
      cnt_q <= '0;
    end else begin
      if (wr_ctrl) cr_q <= reg_wdata & ~CR_ZERO_MASK;
      if (wr_pre)  pr_q <= reg_wdata[PRE_W-1:0];
      if (wr_ien)  ir_q <= reg_wdata[STAT_W-1:0];
      for (int i = 0; i < N_CMP; i++) begin
        if (reg_wr && (idx == IDX_W'(IX_CMP0 + i))) ocr_q[i] <= reg_wdata[CNT_W-1:0];
      end
      sr_q <= (sr_q & ~st_clr) | st_set;
      if (restart)   cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign irq = cr_q[CR_EN] && |(sr_q & ir_q);

  always_comb begin
    reg_rdata = '0;
    case (idx)
      IDX_W'(IX_CTRL):     reg_rdata = cr_q;
      IDX_W'(IX_PRE):      reg_rdata = DATA_W'(pr_q);
      IDX_W'(IX_STAT):     reg_rdata = DATA_W'(sr_q);
      IDX_W'(IX_IEN):      reg_rdata = DATA_W'(ir_q);
      IDX_W'(IX_CMP0):     reg_rdata = DATA_W'(ocr_q[0]);
      IDX_W'(IX_CMP0 + 1): reg_rdata = DATA_W'(ocr_q[1]);
      IDX_W'(IX_CMP0 + 2): reg_rdata = DATA_W'(ocr_q[2]);
      IDX_W'(IX_CAP0),
      IDX_W'(IX_CAP1):     reg_rdata = '0;
      IDX_W'(IX_CNT):      reg_rdata = DATA_W'(cnt_q);
      default:             reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmp_timer3_chk.sv
module cmp_timer3_chk
  import cmp_timer3_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic [DATA_W-1:0]          cr_q,
  input logic [STAT_W-1:0]          sr_q,
  input logic [CNT_W-1:0]           cnt_q,
  input logic [N_CMP-1:0][CNT_W-1:0] ocr_q
);
  // R5: a nonzero new count only comes from stepping while enabled
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cnt_q) && (cnt_q != '0)) |-> $past(cr_q[CR_EN]));

  // R6: a compare flag rises only when the count lands on that compare value
  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    assert_cmp_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_q[i]) |-> (cnt_q == $past(ocr_q[i])));
  end

  // R7: the rollover flag rises only as the count wraps to zero
  assert_roll_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_q[ST_ROLL]) |-> (cnt_q == '0));

  // R10: software reset leaves counter, status and control at zero
  assert_sw_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && (reg_addr[ADDR_W-1:2] == '0) && reg_wdata[CR_SWR])
      |-> ((cnt_q == '0) && (sr_q == '0) && (cr_q == '0)));
endmodule

bind cmp_timer3 cmp_timer3_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .cr_q     (cr_q),
  .sr_q     (sr_q),
  .cnt_q    (cnt_q),
  .ocr_q    (ocr_q)
);

// File: tb/cmp_timer3_tb_top.sv
module cmp_timer3_tb_top;
  localparam int CW   = 10;
  localparam int AW   = 12;
  localparam logic [31:0] MAXV = (32'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_tick = 1'b1;
  logic ref_tick = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cmp_timer3 #(.CNT_W(CW), .PRE_W(12), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .periph_tick(periph_tick), .ref_tick(ref_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [11:0] pr;
    logic [2:0]  src;
    logic        reftk;
    logic [7:0]  cyc;
    logic [9:0]  expv;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{12'd0, 3'd1, 1'b0, 8'd10, 10'd10},
    '{12'd3, 3'd2, 1'b0, 8'd20, 10'd5},
    '{12'd2, 3'd0, 1'b1, 8'd9,  10'd0},
    '{12'd1, 3'd7, 1'b1, 8'd8,  10'd0},
    '{12'd1, 3'd4, 1'b1, 8'd10, 10'd5},
    '{12'd1, 3'd5, 1'b0, 8'd10, 10'd0},
    '{12'd4, 3'd3, 1'b1, 8'd17, 10'd3}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, expv);
    end
  endtask

  // called at a negative edge; write lands on the next rising edge
  task automatic wr(input int ix, input logic [31:0] d);
    reg_addr  = AW'(ix << 2);
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input int ix, output logic [31:0] v);
    reg_addr = AW'(ix << 2);
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(0, v); check("R11 ctrl", v, 0);
    rd(1, v); check("R11 pre", v, 0);
    rd(2, v); check("R11 stat", v, 0);
    rd(3, v); check("R11 ien", v, 0);
    rd(4, v); check("R11 cmp1", v, MAXV);
    rd(6, v); check("R11 cmp3", v, MAXV);
    rd(9, v); check("R11 cnt", v, 0);
    check("R11 irq", {31'd0, irq}, 0);

    // vector table: R3 prescale, R4 source select
    foreach (VEC[k]) begin
      wr(0, 32'h8000);
      wr(1, {20'd0, VEC[k].pr});
      ref_tick = VEC[k].reftk;
      wr(0, 32'h3 | (32'(VEC[k].src) << 6));
      wait_edges(int'(VEC[k].cyc));
      rd(9, v);
      check($sformatf("R3/R4 vec%0d count", k), v, {22'd0, VEC[k].expv});
    end
    ref_tick = 1'b0;
    wr(0, 32'h8000);

    // R2 control masking, R3 prescaler width, R9 enable width
    wr(0, 32'h7DD6); rd(0, v); check("R2 ctrl mask", v, 32'h01C2);
    wr(0, 32'h8000);
    wr(1, 32'hFFFF_F123); rd(1, v); check("R3 pre width", v, 32'h123);
    wr(3, 32'hFF); rd(3, v); check("R9 ien width", v, 32'h3F);
    wr(3, 0);

    // R1 undefined, capture and counter writes ignored
    wr(12, 32'hAB); rd(12, v); check("R1 undefined idx", v, 0);
    wr(7, 32'h55);  rd(7, v);  check("R1 capture ro", v, 0);
    wr(9, 32'h55);  rd(9, v);  check("R1 counter ro", v, 0);
    rd(10, v); check("R1 idx10 zero", v, 0);

    // R6 compare timing, R9 irq
    wr(1, 0); wr(3, 1); wr(4, 5); wr(5, 7); wr(6, 100);
    wr(0, 32'h43);
    wait_edges(4);
    rd(9, v); check("R6 cnt before match", v, 4);
    rd(2, v); check("R6 no early flag", v, 0);
    check("R9 irq low", {31'd0, irq}, 0);
    wait_edges(1);
    rd(2, v); check("R6 cmp1 flag", v, 1);
    check("R9 irq high", {31'd0, irq}, 1);
    wait_edges(2);
    rd(2, v); check("R6 cmp2 flag", v, 3);

    // R8 write-one-to-clear
    wr(2, 2); rd(2, v); check("R8 clear bit1", v, 1);
    wr(2, 0); rd(2, v); check("R8 zero no effect", v, 1);

    // R9 gating by enable, R5 hold / resume / restart
    wr(0, 32'h40);
    check("R9 irq gated off", {31'd0, irq}, 0);
    rd(2, v); check("R9 flag kept", v, 1);
    rd(9, c);
    wait_edges(5);
    rd(9, v); check("R5 hold disabled", v, c);
    wr(0, 32'h41);
    wait_edges(6);
    rd(9, v); check("R5 resume", v, c + 6);
    wr(2, 1); rd(2, v); check("R8 clear bit0", v, 0);
    check("R9 irq after clear", {31'd0, irq}, 0);
    wr(0, 32'h40);
    wr(0, 32'h43);
    wait_edges(3);
    rd(9, v); check("R5 restart", v, 3);

    // R8 set wins over simultaneous clear
    wr(0, 32'h8000);
    wr(4, 1);
    wr(0, 32'h43);
    wr(2, 1);
    rd(2, v); check("R8 set wins", v, 1);

    // R7 rollover (compares at reset value all-ones)
    wr(0, 32'h8000);
    wr(3, 32'h20);
    wr(0, 32'h43);
    wait_edges(int'(MAXV) - 1);
    rd(2, v); check("R7 no early roll", v, 0);
    wait_edges(1);
    rd(9, v); check("R7 at max", v, MAXV);
    rd(2, v); check("R6 all compares at max", v, 32'h07);
    check("R9 irq masked", {31'd0, irq}, 0);
    wait_edges(1);
    rd(9, v); check("R7 wrapped", v, 0);
    rd(2, v); check("R7 roll flag", v, 32'h27);
    check("R9 irq roll", {31'd0, irq}, 1);

    // R10 software reset mid-run
    wr(1, 32'h5);
    wr(0, 32'h8043);
    rd(0, v); check("R10 ctrl self-clear", v, 0);
    rd(2, v); check("R10 stat", v, 0);
    rd(9, v); check("R10 cnt", v, 0);
    rd(1, v); check("R10 pre", v, 0);
    rd(4, v); check("R10 cmp1", v, MAXV);
    check("R10 irq", {31'd0, irq}, 0);
    wait_edges(4);
    rd(9, v); check("R10 stays stopped", v, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule